// File: doc/BRIEF.md
# Expansion Board Autoconfiguration Responder

This block models the identification and address-assignment logic of a plug-and-play memory expansion board on a 16-bit host bus. After reset, an unconfigured board shows up in a small configuration window. Each logical 8-bit identification register is read back as two 4-bit halves at two neighbouring word addresses. The half is driven on data lines D15..D12, and D11..D0 read as ones.

The host reads the board type, the memory size code and the manufacturer identifier. It then writes the upper byte of the base address it has chosen for the board. That write latches the base, raises the configured flag and takes the board out of the configuration window. A write to the shut-up registers also takes the board out of the window, but it assigns no base, so the host can skip the board. A board built with no memory fitted never answers.

The response is registered. An access presented with `strobe` high at a rising clock edge is answered on the outputs during the following cycle. The memory array and the full bus handshake are not part of this block.

Top module: `autocfg_responder`

## Requirements
- R1: While reset is asserted and after it is released, `responded` is 0, `rd_data` is 0, `configured` is 0 and `base_addr` is 0.
- R2: When the board is visible, an access with `strobe` high at an edge raises `responded` for exactly the next cycle. For a read, `rd_data` in that cycle is {nybble, 12'hFFF}. At all other times `rd_data` is 0.
- R3: A read at byte offset 0x00 (the offset is {addr_hi, 1'b0}) returns nybble 0xE, which identifies an older-bus memory board whose memory joins the free pool.
- R4: A read at offset 0x02 returns the size code for parameter `RAM_MB`: 1 gives 5, 2 gives 6, 4 gives 7, and 8 gives 0.
- R5: Reads at offsets 0x10 and 0x12 return 0xA, and reads at 0x14 and 0x16 return 0xB. Together these four halves form the manufacturer identifier.
- R6: A read at any other offset returns nybble 0xF.
- R7: A write at offset 0x48 loads `wr_data_hi` into `base_addr` (address bits 23..16) and sets `configured`. After that the board never responds again until reset.
- R8: A write at offset 0x4C or 0x4E hides the board and leaves `configured` and `base_addr` unchanged. Later accesses get no response, and a later write to 0x48 is ignored.
- R9: A write to any other offset is acknowledged but changes nothing. Later identification reads return the same values, and `configured` and `base_addr` stay unchanged.
- R10: When `RAM_MB` is not 1, 2, 4 or 8, the board is never visible: `responded` and `rd_data` stay 0.
- R11: A reset makes a hidden board visible again and clears `configured` and `base_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Access to the configuration window in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr_hi | input | 7 | Address bits A7..A1 of the access |
| wr_data_hi | input | 8 | Write data bits D15..D8 |
| rd_data | output | 16 | Registered read data |
| responded | output | 1 | The board answered the previous cycle's access |
| configured | output | 1 | A base address has been assigned |
| base_addr | output | 8 | Assigned base, address bits 23..16 |

## Verification
The assertions assume that every access lasts exactly one cycle of `strobe`, and that `we` and the address are valid whenever `strobe` is high. The properties relating `responded` to the previous cycle rely on this. The driver task raises `strobe` on one falling edge and clears it on the next, so each access spans exactly one rising edge. It always keeps `we` and the address defined. Two extra instances see the same stimulus: one holds the 8 MB size code and one has no memory fitted.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;

    localparam logic [7:0] OFF_TYPE_HI  = 8'h00;
    localparam logic [7:0] OFF_TYPE_LO  = 8'h02;
    localparam logic [7:0] OFF_MFG_A0   = 8'h10;
    localparam logic [7:0] OFF_MFG_A1   = 8'h12;
    localparam logic [7:0] OFF_MFG_B0   = 8'h14;
    localparam logic [7:0] OFF_MFG_B1   = 8'h16;
    localparam logic [7:0] OFF_BASE     = 8'h48;
    localparam logic [7:0] OFF_QUIET_LO = 8'h4C;
    localparam logic [7:0] OFF_QUIET_HI = 8'h4F;

    localparam logic [3:0] NYB_TYPE  = 4'hE;
    localparam logic [3:0] NYB_MFG_A = 4'hA;
    localparam logic [3:0] NYB_MFG_B = 4'hB;
    localparam logic [3:0] NYB_BLANK = 4'hF;

    typedef struct packed {
        logic       visible;
        logic       configured;
        logic [7:0] base;
    } cfg_state_t;

    typedef struct packed {
        logic        ack;
        logic [15:0] rdata;
    } resp_t;

    function automatic logic [3:0] size_code(input int mb);
        case (mb)
            1:       size_code = 4'h5;
            2:       size_code = 4'h6;
            4:       size_code = 4'h7;
            8:       size_code = 4'h0;
            default: size_code = 4'hF;
        endcase
    endfunction

    function automatic logic ram_fitted(input int mb);
        ram_fitted = (mb == 1) || (mb == 2) || (mb == 4) || (mb == 8);
    endfunction

endpackage

// File: rtl/autocfg_idrom.sv
module autocfg_idrom
    import autocfg_pkg::*;
#(
    parameter logic [3:0] SIZE_NYB = 4'h6
) (
    input  logic [7:0] offset,
    output logic [3:0] nybble
);

    always_comb begin
        case (offset)
            OFF_TYPE_HI:             nybble = NYB_TYPE;
            OFF_TYPE_LO:             nybble = SIZE_NYB;
            OFF_MFG_A0, OFF_MFG_A1:  nybble = NYB_MFG_A;
            OFF_MFG_B0, OFF_MFG_B1:  nybble = NYB_MFG_B;
            default:                 nybble = NYB_BLANK;
        endcase
    end

endmodule

// File: rtl/autocfg_ctrl.sv
module autocfg_ctrl
    import autocfg_pkg::*;
#(
    parameter bit FITTED = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] offset,
    input  logic [7:0] wdata_hi,
    output logic       visible,
    output logic       configured,
    output logic [7:0] base
);

    cfg_state_t st_d, st_q;
    logic       is_base_wr;
    logic       is_quiet_wr;

    always_comb begin
        is_base_wr  = wr_hit && (offset == OFF_BASE);
        is_quiet_wr = wr_hit && (offset >= OFF_QUIET_LO) && (offset <= OFF_QUIET_HI);
        st_d = st_q;
        if (is_base_wr) begin
            st_d.base       = wdata_hi;
            st_d.configured = 1'b1;
            st_d.visible    = 1'b0;
        end
        if (is_quiet_wr) begin
            st_d.visible = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.visible    <= FITTED;
            st_q.configured <= 1'b0;
            st_q.base       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign visible    = st_q.visible;
    assign configured = st_q.configured;
    assign base       = st_q.base;

    // R7
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.configured |=> st_q.configured);

    // R7
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.configured |=> $stable(st_q.base));

    // R8
    hidden_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.visible |=> !st_q.visible);

endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder
    import autocfg_pkg::*;
#(
    parameter int RAM_MB = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  logic        we,
    input  logic [6:0]  addr_hi,
    input  logic [7:0]  wr_data_hi,
    output logic [15:0] rd_data,
    output logic        responded,
    output logic        configured,
    output logic [7:0]  base_addr
);

    localparam logic [3:0] SIZE_NYB = size_code(RAM_MB);
    localparam bit         FITTED   = ram_fitted(RAM_MB);
    localparam logic [11:0] PAD     = '1;

    logic [7:0] offset;
    logic [3:0] nybble;
    logic       visible;
    logic       hit;
    resp_t      resp_d, resp_q;

    assign offset = {addr_hi, 1'b0};
    assign hit    = strobe && visible;

    autocfg_idrom #(.SIZE_NYB(SIZE_NYB)) u_idrom (
        .offset (offset),
        .nybble (nybble)
    );

    autocfg_ctrl #(.FITTED(FITTED)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (hit && we),
        .offset     (offset),
        .wdata_hi   (wr_data_hi),
        .visible    (visible),
        .configured (configured),
        .base       (base_addr)
    );

    always_comb begin
        resp_d.ack   = hit;
        resp_d.rdata = (hit && !we) ? {nybble, PAD} : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign responded = resp_q.ack;
    assign rd_data   = resp_q.rdata;

    // R2
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        responded |-> $past(strobe));

    // R10
    silent_when_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        responded |-> $past(visible));

    // R2
    pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (responded && $past(!we)) |-> (rd_data[11:0] == 12'hFFF));

endmodule

// File: tb/autocfg_responder_test.sv
module autocfg_responder_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          cyc;
        string       tag;
        logic        ack;
        logic [15:0] rd;
        logic        cfg;
        logic [7:0]  base;
        logic        ack8;
        logic [15:0] rd8;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  addr_hi = '0;
    logic [7:0]  wr_data_hi = '0;
    logic [15:0] rd_data, rd8, rd0;
    logic        responded, resp8, resp0;
    logic        configured, cfg8, cfg0;
    logic [7:0]  base_addr, base8, base0;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    item_t q[$];

    logic       m_vis [2];
    logic       m_cfg [2];
    logic [7:0] m_base [2];
    logic [3:0] m_code [2];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    autocfg_responder #(.RAM_MB(2)) uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .we(we), .addr_hi(addr_hi),
        .wr_data_hi(wr_data_hi), .rd_data(rd_data), .responded(responded),
        .configured(configured), .base_addr(base_addr));

    autocfg_responder #(.RAM_MB(8)) uut8 (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .we(we), .addr_hi(addr_hi),
        .wr_data_hi(wr_data_hi), .rd_data(rd8), .responded(resp8),
        .configured(cfg8), .base_addr(base8));

    autocfg_responder #(.RAM_MB(0)) uut_none (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .we(we), .addr_hi(addr_hi),
        .wr_data_hi(wr_data_hi), .rd_data(rd0), .responded(resp0),
        .configured(cfg0), .base_addr(base0));

    function automatic logic [3:0] exp_nyb(input logic [3:0] code, input logic [7:0] off);
        case (off)
            8'h00:        exp_nyb = 4'hE;
            8'h02:        exp_nyb = code;
            8'h10, 8'h12: exp_nyb = 4'hA;
            8'h14, 8'h16: exp_nyb = 4'hB;
            default:      exp_nyb = 4'hF;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_vis[k]  = 1'b1;
            m_cfg[k]  = 1'b0;
            m_base[k] = 8'h00;
        end
    endtask

    task automatic check(input string tag, input bit ok, input string got, input string want);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, got, want);
        end
    endtask

    task automatic acc(input string tag, input bit w, input logic [7:0] off, input logic [7:0] d);
        item_t it;
        logic        a [2];
        logic [15:0] r [2];
        @(negedge clk);
        strobe = 1'b1;
        we = w;
        addr_hi = off[7:1];
        wr_data_hi = d;
        for (int k = 0; k < 2; k++) begin
            a[k] = m_vis[k];
            r[k] = (a[k] && !w) ? {exp_nyb(m_code[k], off), 12'hFFF} : 16'h0000;
            if (a[k] && w) begin
                if (off == 8'h48) begin
                    m_base[k] = d;
                    m_cfg[k]  = 1'b1;
                    m_vis[k]  = 1'b0;
                end
                if (off >= 8'h4C && off <= 8'h4F) m_vis[k] = 1'b0;
            end
        end
        it.cyc = cyc; it.tag = tag;
        it.ack = a[0]; it.rd = r[0]; it.cfg = m_cfg[0]; it.base = m_base[0];
        it.ack8 = a[1]; it.rd8 = r[1];
        q.push_back(it);
        @(negedge clk);
        strobe = 1'b0;
        we = 1'b0;
    endtask

    // Monitor: compares each queued expectation one cycle after its access.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc == cyc - 1) begin
            item_t it;
            it = q.pop_front();
            check(it.tag,
                  responded == it.ack && rd_data == it.rd && configured == it.cfg && base_addr == it.base,
                  $sformatf("ack=%0b rd=%h cfg=%0b base=%h", responded, rd_data, configured, base_addr),
                  $sformatf("ack=%0b rd=%h cfg=%0b base=%h", it.ack, it.rd, it.cfg, it.base));
            check({it.tag, " 8MB"}, resp8 == it.ack8 && rd8 == it.rd8,
                  $sformatf("ack=%0b rd=%h", resp8, rd8),
                  $sformatf("ack=%0b rd=%h", it.ack8, it.rd8));
            check({it.tag, " R10 none fitted"}, resp0 == 1'b0 && rd0 == 16'h0 && cfg0 == 1'b0,
                  $sformatf("ack=%0b rd=%h cfg=%0b", resp0, rd0, cfg0), "ack=0 rd=0000 cfg=0");
        end
    end

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        m_code[0] = 4'h6;
        m_code[1] = 4'h0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", responded == 0 && rd_data == 0 && configured == 0 && base_addr == 0,
              $sformatf("%0b %h %0b %h", responded, rd_data, configured, base_addr), "0 0000 0 00");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", responded == 0 && configured == 0 && base_addr == 0,
              $sformatf("%0b %0b %h", responded, configured, base_addr), "0 0 00");

        acc("R3 type", 1'b0, 8'h00, 8'h00);
        acc("R4 size", 1'b0, 8'h02, 8'h00);
        acc("R5 mfg 10", 1'b0, 8'h10, 8'h00);
        acc("R5 mfg 12", 1'b0, 8'h12, 8'h00);
        acc("R5 mfg 14", 1'b0, 8'h14, 8'h00);
        acc("R5 mfg 16", 1'b0, 8'h16, 8'h00);
        acc("R6 blank 04", 1'b0, 8'h04, 8'h00);
        acc("R6 blank 20", 1'b0, 8'h20, 8'h00);
        acc("R6 blank 46", 1'b0, 8'h46, 8'h00);
        acc("R9 write 20", 1'b1, 8'h20, 8'h55);
        acc("R9 write 40", 1'b1, 8'h40, 8'hAA);
        acc("R9 type after", 1'b0, 8'h00, 8'h00);
        acc("R9 size after", 1'b0, 8'h02, 8'h00);
        acc("R7 base write", 1'b1, 8'h48, 8'h3C);
        acc("R7 read hidden", 1'b0, 8'h00, 8'h00);
        acc("R7 quiet after cfg", 1'b1, 8'h4C, 8'h00);
        acc("R7 rewrite base", 1'b1, 8'h48, 8'h99);

        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        check("R11 reset clears", configured == 0 && base_addr == 0 && responded == 0,
              $sformatf("%0b %h %0b", configured, base_addr, responded), "0 00 0");
        rst_n = 1'b1;

        acc("R11 visible again", 1'b0, 8'h00, 8'h00);
        acc("R8 quiet write 4E", 1'b1, 8'h4E, 8'h12);
        acc("R8 read hidden", 1'b0, 8'h02, 8'h00);
        acc("R8 base ignored", 1'b1, 8'h48, 8'h77);
        acc("R8 still hidden", 1'b0, 8'h10, 8'h00);

        repeat (3) @(negedge clk);
        check("R8 queue drained", q.size() == 0, $sformatf("%0d", q.size()), "0");
        finish_run();
    end

endmodule